// File: doc/BRIEF.md
# Shared-RAM Transmit FIFO Bank

This block carves one single-port RAM into a small number of independent circular transmit queues, one per IN endpoint. Software gives each queue a base word address and a length in words through a 32-bit setup word. After that, the bus side writes words into the queue that an endpoint number selects, and the serial engine reads words back out of any queue in first-in, first-out order.

The RAM has one access port, so a read and a write cannot happen in the same cycle. A read from the serial engine takes the port, and a bus-side write waits through `push_ready`. Each queue reports how many words are free, whether it is full or empty, and a sticky error bit. The error bit records a write to a full queue or a read from an empty one. The area of the RAM that receives data sits outside these queues. Software must keep the queue regions apart; the block does not check this.

Top module: `txfifo_bank`

## Requirements
- R1: The setup word for endpoint `cfg_ep` takes its depth in words from bits [31:16] and its base word address from bits [15:0]. Writing it with `cfg_we` empties that queue in the next cycle: free count equals the depth, empty is 1, full is 1 only for depth 0, and the error bit is 0.
- R2: An accepted write stores its data at RAM word (base + write index). The write index starts at 0, goes up by one per stored word, and returns to 0 after reaching depth-1. Queues whose regions overlap therefore see each other's data.
- R3: A read request to a non-empty queue returns the oldest stored word on `pop_data`, with `pop_valid` high in the next cycle. Words come out in the order they were written.
- R4: Each queue's free count equals depth minus occupancy. Empty means occupancy 0, and full means occupancy equals depth.
- R5: `push_ready` is low in a cycle with `cfg_we` high, or with `pop_req` aimed at a non-empty queue. In every other cycle it is high.
- R6: A write to a full queue leaves the queue unchanged and sets that endpoint's error bit.
- R7: A read from an empty queue gives `pop_valid` low in the next cycle, leaves the queue unchanged and sets that endpoint's error bit.
- R8: An error bit stays set until reset or until that endpoint's setup word is written.
- R9: A write, read or setup aimed at one endpoint changes no other endpoint's free count, flags or error bit.
- R10: After reset, every queue has depth 0: free count 0, full and empty both 1, error 0, and `pop_valid` 0.
- R11: A read request in a cycle with `cfg_we` high is ignored. No data comes out and no error is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_ep | input | 2 | Endpoint the setup word is for |
| cfg_word | input | 32 | Setup word: depth [31:16], base [15:0] |
| push_valid | input | 1 | Bus-side write request |
| push_ep | input | 2 | Endpoint to write to |
| push_data | input | 32 | Word to write |
| push_ready | output | 1 | Write taken this cycle |
| pop_req | input | 1 | Serial-engine read request |
| pop_ep | input | 2 | Endpoint to read from |
| pop_valid | output | 1 | `pop_data` holds a read word |
| pop_data | output | 32 | Word read out |
| ep_free | output | 64 | Free word count per endpoint, 16 bits each, endpoint 0 lowest |
| ep_full | output | 4 | Full flag per endpoint |
| ep_empty | output | 4 | Empty flag per endpoint |
| ep_err | output | 4 | Sticky error bit per endpoint |

## Verification
The bench fills and drains each queue at several depths and at both index wrap points. A design with an off-by-one wrap would hand back stale or reordered words there. It writes past full and reads past empty. A design that let these through would corrupt occupancy or raise `pop_valid` with garbage. It issues reads and writes in the same cycle and reads during a setup write. A wrong arbiter would drop or duplicate a word, or report a spurious error. It also places two queues over the same RAM words, which exposes any address that is not base plus index.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int FIELD_W = 16;

  // Setup word layout: depth in the upper half, base in the lower half.
  typedef struct packed {
    logic [FIELD_W-1:0] depth;
    logic [FIELD_W-1:0] base;
  } txf_cfg_t;
endpackage

// File: rtl/txf_ram.sv
module txf_ram #(
  parameter int WORDS  = 320,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  // Single port, registered read: maps onto one block RAM port.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_load,
  input  txf_cfg_t           cfg_in,
  input  logic               push_try,
  input  logic               pop_try,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               full,
  output logic               empty,
  output logic [FIELD_W-1:0] free_cnt,
  output logic               err
);
  logic [FIELD_W-1:0] base_q, depth_q, wptr_q, rptr_q, count_q;
  logic               err_q;
  logic               push_go, pop_go;
  logic [FIELD_W-1:0] wsum, rsum, wptr_nx, rptr_nx;

  assign full     = (count_q == depth_q);
  assign empty    = (count_q == '0);
  assign free_cnt = depth_q - count_q;
  assign err      = err_q;
  assign push_go  = push_try && !full;
  assign pop_go   = pop_try && !empty;

  assign wsum    = base_q + wptr_q;
  assign rsum    = base_q + rptr_q;
  assign wr_addr = wsum[ADDR_W-1:0];
  assign rd_addr = rsum[ADDR_W-1:0];

  assign wptr_nx = (wptr_q == depth_q - 1'b1) ? '0 : wptr_q + 1'b1;
  assign rptr_nx = (rptr_q == depth_q - 1'b1) ? '0 : rptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      depth_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      err_q   <= 1'b0;
    end else if (cfg_load) begin
      base_q  <= cfg_in.base;
      depth_q <= cfg_in.depth;
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (push_go) wptr_q <= wptr_nx;
      if (pop_go)  rptr_q <= rptr_nx;
      case ({push_go, pop_go})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if ((push_try && full) || (pop_try && empty)) err_q <= 1'b1;
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count_q <= depth_q);

  assert_full_push_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (push_try && full && !pop_try && !cfg_load)
      |=> (count_q == $past(count_q)) && (wptr_q == $past(wptr_q)) && err_q);

  assert_empty_pop_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_try && empty && !cfg_load) |=> err_q && (rptr_q == $past(rptr_q)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (err_q && !cfg_load) |=> err_q);

  assert_cfg_empties_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> empty && !err_q && (free_cnt == $past(cfg_in.depth)));
endmodule

// File: rtl/txf_arb.sv
module txf_arb #(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2,
  parameter int ADDR_W = 9
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [EP_W-1:0]                cfg_ep,
  input  logic                           push_valid,
  input  logic [EP_W-1:0]                push_ep,
  input  logic                           pop_req,
  input  logic [EP_W-1:0]                pop_ep,
  input  logic [NUM_EP-1:0]              ep_full,
  input  logic [NUM_EP-1:0]              ep_empty,
  input  logic [NUM_EP-1:0][ADDR_W-1:0]  wr_addr,
  input  logic [NUM_EP-1:0][ADDR_W-1:0]  rd_addr,
  output logic                           push_ready,
  output logic [NUM_EP-1:0]              push_try,
  output logic [NUM_EP-1:0]              pop_try,
  output logic [NUM_EP-1:0]              cfg_load,
  output logic                           pop_go,
  output logic                           ram_we,
  output logic [ADDR_W-1:0]              ram_addr
);
  logic pop_live;

  // Setup writes block both sides; a read of a non-empty queue owns the port.
  assign pop_live   = pop_req && !cfg_we;
  assign pop_go     = pop_live && !ep_empty[pop_ep];
  assign push_ready = !cfg_we && !pop_go;
  assign ram_we     = push_valid && push_ready && !ep_full[push_ep];
  assign ram_addr   = pop_go ? rd_addr[pop_ep] : wr_addr[push_ep];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
    assign push_try[i] = push_valid && push_ready && (push_ep == EP_W'(i));
    assign pop_try[i]  = pop_live && (pop_ep == EP_W'(i));
    assign cfg_load[i] = cfg_we && (cfg_ep == EP_W'(i));
  end

  assert_one_access_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, pop_go}));

  assert_stall_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready) |-> (cfg_we || pop_req));

  assert_single_target_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push_try) && $onehot0(pop_try) && $onehot0(cfg_load));
endmodule

// File: rtl/txfifo_bank.sv
module txfifo_bank
  import txf_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int RAM_WORDS = 320,
  parameter int DATA_W    = 32,
  parameter int EP_W      = $clog2(NUM_EP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [EP_W-1:0]           cfg_ep,
  input  logic [2*FIELD_W-1:0]      cfg_word,
  input  logic                      push_valid,
  input  logic [EP_W-1:0]           push_ep,
  input  logic [DATA_W-1:0]         push_data,
  output logic                      push_ready,
  input  logic                      pop_req,
  input  logic [EP_W-1:0]           pop_ep,
  output logic                      pop_valid,
  output logic [DATA_W-1:0]         pop_data,
  output logic [NUM_EP*FIELD_W-1:0] ep_free,
  output logic [NUM_EP-1:0]         ep_full,
  output logic [NUM_EP-1:0]         ep_empty,
  output logic [NUM_EP-1:0]         ep_err
);
  localparam int ADDR_W = $clog2(RAM_WORDS);

  txf_cfg_t                  cfg_s;
  logic [NUM_EP-1:0]         push_try, pop_try, cfg_load;
  logic [NUM_EP-1:0][ADDR_W-1:0] wr_addr, rd_addr;
  logic                      pop_go, ram_we;
  logic [ADDR_W-1:0]         ram_addr;

  assign cfg_s = txf_cfg_t'(cfg_word);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    txf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .cfg_load (cfg_load[i]),
      .cfg_in   (cfg_s),
      .push_try (push_try[i]),
      .pop_try  (pop_try[i]),
      .wr_addr  (wr_addr[i]),
      .rd_addr  (rd_addr[i]),
      .full     (ep_full[i]),
      .empty    (ep_empty[i]),
      .free_cnt (ep_free[i*FIELD_W +: FIELD_W]),
      .err      (ep_err[i])
    );
  end

  txf_arb #(.NUM_EP(NUM_EP), .EP_W(EP_W), .ADDR_W(ADDR_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_ep     (cfg_ep),
    .push_valid (push_valid),
    .push_ep    (push_ep),
    .pop_req    (pop_req),
    .pop_ep     (pop_ep),
    .ep_full    (ep_full),
    .ep_empty   (ep_empty),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .push_ready (push_ready),
    .push_try   (push_try),
    .pop_try    (pop_try),
    .cfg_load   (cfg_load),
    .pop_go     (pop_go),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr)
  );

  txf_ram #(.WORDS(RAM_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (push_data),
    .rdata (pop_data)
  );

  always_ff @(posedge clk) begin
    if (rst) pop_valid <= 1'b0;
    else     pop_valid <= pop_go;
  end

  assert_valid_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> $past(pop_req && !cfg_we));

  assert_no_data_in_cfg_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !pop_valid);
endmodule

// File: tb/txfifo_bank_bench.sv
module txfifo_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NEP = 4;
  localparam int RW  = 320;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ep = '0;
  logic [31:0] cfg_word = '0;
  logic        push_valid = 1'b0;
  logic [1:0]  push_ep = '0;
  logic [31:0] push_data = '0;
  logic        push_ready;
  logic        pop_req = 1'b0;
  logic [1:0]  pop_ep = '0;
  logic        pop_valid;
  logic [31:0] pop_data;
  logic [63:0] ep_free;
  logic [3:0]  ep_full, ep_empty, ep_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_base[NEP], m_dep[NEP], m_wp[NEP], m_rp[NEP], m_cnt[NEP];
  bit m_err[NEP];
  logic [31:0] m_mem[RW];

  always #(CLK_PERIOD/2) clk = ~clk;

  txfifo_bank u_txfifo_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_word(cfg_word),
    .push_valid(push_valid), .push_ep(push_ep), .push_data(push_data),
    .push_ready(push_ready), .pop_req(pop_req), .pop_ep(pop_ep),
    .pop_valid(pop_valid), .pop_data(pop_data), .ep_free(ep_free),
    .ep_full(ep_full), .ep_empty(ep_empty), .ep_err(ep_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    for (int e = 0; e < NEP; e++) begin
      int fr;
      fr = int'(ep_free[e*16 +: 16]);
      chk(fr == m_dep[e] - m_cnt[e], {tag, " R4/R9 free"}, fr, m_dep[e] - m_cnt[e]);
      chk(ep_full[e] == (m_cnt[e] == m_dep[e]), {tag, " R4 full"}, ep_full[e], m_cnt[e] == m_dep[e]);
      chk(ep_empty[e] == (m_cnt[e] == 0), {tag, " R4 empty"}, ep_empty[e], m_cnt[e] == 0);
      chk(ep_err[e] == m_err[e], {tag, " R8/R9 err"}, ep_err[e], m_err[e]);
    end
  endtask

  function automatic void model_cfg(input int e, input int b, input int d);
    m_base[e] = b; m_dep[e] = d; m_wp[e] = 0; m_rp[e] = 0; m_cnt[e] = 0; m_err[e] = 0;
  endfunction

  function automatic void model_push(input int e, input logic [31:0] d);
    if (m_cnt[e] == m_dep[e]) m_err[e] = 1;
    else begin
      m_mem[(m_base[e] + m_wp[e]) % RW] = d;
      m_wp[e] = (m_wp[e] == m_dep[e] - 1) ? 0 : m_wp[e] + 1;
      m_cnt[e]++;
    end
  endfunction

  task automatic do_cfg(input int e, input int b, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ep = 2'(e); cfg_word = {16'(d), 16'(b)};
    @(negedge clk);
    cfg_we = 1'b0;
    model_cfg(e, b, d);
    check_state("R1 cfg");
  endtask

  task automatic do_push(input int e, input logic [31:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_ep = 2'(e); push_data = d;
    #1 chk(push_ready == 1'b1, "R5 ready idle", push_ready, 1);
    @(negedge clk);
    push_valid = 1'b0;
    if (m_cnt[e] == m_dep[e]) begin
      model_push(e, d);
      check_state("R6 full push");
    end else begin
      model_push(e, d);
      check_state("R2 push");
    end
  endtask

  task automatic do_pop(input int e);
    logic [31:0] exp_d;
    @(negedge clk);
    pop_req = 1'b1; pop_ep = 2'(e);
    @(negedge clk);
    pop_req = 1'b0;
    if (m_cnt[e] == 0) begin
      chk(pop_valid == 1'b0, "R7 empty pop valid", pop_valid, 0);
      m_err[e] = 1;
    end else begin
      exp_d = m_mem[(m_base[e] + m_rp[e]) % RW];
      chk(pop_valid == 1'b1, "R3 pop valid", pop_valid, 1);
      chk(pop_data == exp_d, "R3 pop data", pop_data, exp_d);
      m_rp[e] = (m_rp[e] == m_dep[e] - 1) ? 0 : m_rp[e] + 1;
      m_cnt[e]--;
    end
    check_state("R3/R7 pop");
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NEP; e++) model_cfg(e, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk(pop_valid == 1'b0, "R10 pop_valid", pop_valid, 0);
    check_state("R10 reset");

    // Sweep: fill past full, drain past empty, then interleave across the wrap.
    do_cfg(0, 0, 3);
    do_cfg(1, 3, 5);
    do_cfg(2, 8, 1);
    do_cfg(3, 9, 7);
    for (int e = 0; e < NEP; e++) begin
      for (int k = 0; k <= m_dep[e]; k++) do_push(e, {8'hA0 + 8'(e), 8'(k), 16'h1234});
      for (int k = 0; k <= m_dep[e]; k++) do_pop(e);
      for (int k = 0; k < 2 * m_dep[e] + 1; k++) begin
        do_push(e, {8'hB0 + 8'(e), 24'(k)});
        do_pop(e);
      end
    end

    // R8: errors clear only on a setup write
    for (int e = 0; e < NEP; e++) do_cfg(e, m_base[e], m_dep[e]);

    // R5: a read of a non-empty queue stalls a write for one cycle
    do_push(0, 32'h0000_0A0A);
    do_push(0, 32'h0000_0B0B);
    @(negedge clk);
    pop_req = 1'b1; pop_ep = 2'd0;
    push_valid = 1'b1; push_ep = 2'd1; push_data = 32'hCAFE_0001;
    #1 chk(push_ready == 1'b0, "R5 pop wins", push_ready, 0);
    @(negedge clk);
    chk(pop_valid == 1'b1, "R5 pop valid", pop_valid, 1);
    chk(pop_data == 32'h0000_0A0A, "R5 pop data", pop_data, 32'h0000_0A0A);
    pop_req = 1'b0;
    m_rp[0] = 1; m_cnt[0]--;
    #1 chk(push_ready == 1'b1, "R5 push resumes", push_ready, 1);
    @(negedge clk);
    push_valid = 1'b0;
    model_push(1, 32'hCAFE_0001);
    check_state("R5 after stall");
    do_pop(1);

    // R5/R7: a read of an empty queue does not stall the write
    @(negedge clk);
    pop_req = 1'b1; pop_ep = 2'd2;
    push_valid = 1'b1; push_ep = 2'd1; push_data = 32'hCAFE_0002;
    #1 chk(push_ready == 1'b1, "R5 empty pop no stall", push_ready, 1);
    @(negedge clk);
    pop_req = 1'b0; push_valid = 1'b0;
    chk(pop_valid == 1'b0, "R7 empty pop valid", pop_valid, 0);
    m_err[2] = 1;
    model_push(1, 32'hCAFE_0002);
    check_state("R7 concurrent");
    do_pop(1);

    // R11: a read during a setup write is dropped without an error
    @(negedge clk);
    cfg_we = 1'b1; cfg_ep = 2'd3; cfg_word = {16'd4, 16'd30};
    pop_req = 1'b1; pop_ep = 2'd0;
    #1 chk(push_ready == 1'b0, "R5 cfg blocks", push_ready, 0);
    @(negedge clk);
    cfg_we = 1'b0; pop_req = 1'b0;
    chk(pop_valid == 1'b0, "R11 pop ignored", pop_valid, 0);
    model_cfg(3, 30, 4);
    check_state("R11 cfg+pop");
    do_pop(0);

    // R2: overlapping regions expose base + index addressing and the wrap
    do_cfg(0, 40, 2);
    do_push(0, 32'h1111_0000);
    do_push(0, 32'h2222_0000);
    do_cfg(1, 41, 2);
    do_push(1, 32'h3333_0000);
    do_pop(0);
    chk(pop_data == 32'h1111_0000, "R2 first word", pop_data, 32'h1111_0000);
    do_push(0, 32'h4444_0000);
    do_pop(0);
    chk(pop_data == 32'h3333_0000, "R2 overlap word", pop_data, 32'h3333_0000);
    do_pop(0);
    chk(pop_data == 32'h4444_0000, "R2 wrapped word", pop_data, 32'h4444_0000);

    // Depth ramp on one endpoint, with neighbours holding data (R9)
    do_push(1, 32'h5555_0000);
    for (int d = 0; d <= 8; d++) begin
      do_cfg(2, 100, d);
      for (int k = 0; k <= d; k++) do_push(2, {16'(d), 16'(k)});
      for (int k = 0; k <= d; k++) do_pop(2);
    end
    do_pop(1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule